// File: doc/BRIEF.md
# Register File with Mapped Status Register

This block is the operand store of a small 16-bit processor. It has two combinational read ports and one synchronous write port, and each port is addressed by a 3-bit register code. Code 000 names a constant-zero register that accepts writes and discards them. Codes 001 to 100 name four general-purpose registers. Code 101 names a status register that holds the four ALU condition flags. Codes 110 and 111 name nothing inside this block.

The status register is loaded only from the ALU flag vector, and only when a dedicated flag-load enable is high. The normal write port never reaches it. The stored zero flag is also driven on its own output, so that instruction-sequencing logic can test it without using a read port. Every register is cleared by a synchronous, active-high reset.

Top module: `regbank16`

## Requirements
- R1: Code 000 reads as 0x0000 on both read ports at all times, including in the cycle right after a write-port write to code 000.
- R2: When `wr_en` is high at a rising clock edge, codes 001, 010, 011 and 100 load `wr_data` into general registers 1 to 4. A read of that code shows the new value after the edge. When `wr_en` is low, no general register changes.
- R3: A read of code 101 returns the stored flags as {12'b0, V, C, N, Z}, with Z in bit 0, N in bit 1, C in bit 2 and V in bit 3. Bits 15 to 4 read as zero.
- R4: A write-port write to code 101 has no effect: the flags and all general registers keep their values.
- R5: At a rising edge with `flag_en` high, the flag register loads `alu_flags`, whose bit layout is the same as R3 (bit 0 Z, bit 1 N, bit 2 C, bit 3 V). With `flag_en` low, it holds its value.
- R6: Codes 110 and 111 read as 0x0000, and write-port writes to them change no register.
- R7: A synchronous reset (`rst` high at a rising edge) clears all four general registers and the flag register.
- R8: `z_out` always equals the stored Z flag, which is bit 0 of the value read at code 101.
- R9: The two read ports work independently, and both may select the same code in the same cycle.
- R10: A register write and a flag load in the same cycle both take effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | Write-port enable |
| wr_sel | input | 3 | Write-port register code |
| wr_data | input | 16 | Write-port data |
| flag_en | input | 1 | Flag-register load enable |
| alu_flags | input | 4 | Flags from the ALU: bit 0 Z, bit 1 N, bit 2 C, bit 3 V |
| ra_sel | input | 3 | Read port A register code |
| rb_sel | input | 3 | Read port B register code |
| ra_data | output | 16 | Read port A value (combinational) |
| rb_data | output | 16 | Read port B value (combinational) |
| z_out | output | 1 | Stored zero flag |

## Verification
Each read is combinational, so a wrong stored value shows on a port in the first cycle after the faulty edge in which that code is selected. The bench therefore compares both read ports and `z_out` with its model in every cycle. Any state the design holds wrongly is visible within one cycle of being selected. A write that should have been ignored, or a flag that failed to hold, shows up at the next read of the affected code. The random phase selects every code often, so such errors stay hidden for only a few cycles.

// File: rtl/regf_pkg.sv
package regf_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_ZERO = 3'd0;
  localparam logic [CODE_W-1:0] CODE_FLAG = 3'd5;

  // True when the code selects one of the general registers 1..count
  function automatic logic is_gpr(input logic [CODE_W-1:0] code, input int count);
    return (int'(code) >= 1) && (int'(code) <= count);
  endfunction

  // Array slot of a general-register code
  function automatic int gpr_slot(input logic [CODE_W-1:0] code);
    return int'(code) - 1;
  endfunction
endpackage

// File: rtl/regf_gpr_bank.sv
module regf_gpr_bank
  import regf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_GPR = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [CODE_W-1:0]               wr_sel,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NUM_GPR-1:0][DATA_W-1:0]  gpr_q
);
  logic [NUM_GPR-1:0] wr_hit;
  logic               wr_dropped;

  assign wr_dropped = wr_en && !is_gpr(wr_sel, NUM_GPR);

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
    assign wr_hit[g] = wr_en && is_gpr(wr_sel, NUM_GPR) && (gpr_slot(wr_sel) == g);

    always_ff @(posedge clk) begin
      if (rst)            gpr_q[g] <= '0;
      else if (wr_hit[g]) gpr_q[g] <= wr_data;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      wr_hit[g] |=> gpr_q[g] == $past(wr_data)); // R2
  end

  AST_ONE_HOT_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(gpr_q)); // R2
  AST_UNDEF_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    wr_dropped |=> $stable(gpr_q)); // R4 R6
  AST_GPR_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> gpr_q == '0); // R7
endmodule

// File: rtl/regf_flag_reg.sv
module regf_flag_reg #(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_en,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic [FLAG_W-1:0] flag_q
);
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= '0;
    else if (flag_en) flag_q <= alu_flags;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_en |=> $stable(flag_q)); // R5
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    flag_en |=> flag_q == $past(alu_flags)); // R5
  AST_FLAG_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> flag_q == '0); // R7
endmodule

// File: rtl/regf_read_port.sv
module regf_read_port
  import regf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_GPR = 4,
  parameter int FLAG_W  = 4
) (
  input  logic [CODE_W-1:0]              sel,
  input  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q,
  input  logic [FLAG_W-1:0]              flag_q,
  output logic [DATA_W-1:0]              rdata
);
  localparam int PAD_W = DATA_W - FLAG_W;

  logic sel_flag, sel_gpr;
  assign sel_flag = (sel == CODE_FLAG);
  assign sel_gpr  = is_gpr(sel, NUM_GPR);

  always_comb begin
    rdata = '0;
    if (sel_gpr)       rdata = gpr_q[gpr_slot(sel)];
    else if (sel_flag) rdata = {{PAD_W{1'b0}}, flag_q};
  end

  always_comb begin
    if (sel == CODE_ZERO)
      AST_ZERO_CODE: assert (rdata == '0); // R1
    if (sel_flag)
      AST_RSVD_ZERO: assert (rdata[DATA_W-1:FLAG_W] == '0); // R3
    if (!sel_gpr && !sel_flag)
      AST_UNDEF_READ_ZERO: assert (rdata == '0); // R6
  end
endmodule

// File: rtl/regbank16.sv
module regbank16
  import regf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_GPR = 4,
  parameter int FLAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_en,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic [2:0]        ra_sel,
  input  logic [2:0]        rb_sel,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic              z_out
);
  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q;
  logic [FLAG_W-1:0]              flag_q;

  regf_gpr_bank #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .gpr_q(gpr_q)
  );

  regf_flag_reg #(.FLAG_W(FLAG_W)) u_flags (
    .clk(clk), .rst(rst), .flag_en(flag_en),
    .alu_flags(alu_flags), .flag_q(flag_q)
  );

  regf_read_port #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .FLAG_W(FLAG_W)) u_port_a (
    .sel(ra_sel), .gpr_q(gpr_q), .flag_q(flag_q), .rdata(ra_data)
  );

  regf_read_port #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .FLAG_W(FLAG_W)) u_port_b (
    .sel(rb_sel), .gpr_q(gpr_q), .flag_q(flag_q), .rdata(rb_data)
  );

  assign z_out = flag_q[0];

  AST_Z_TRACKS: assert property (@(posedge clk) disable iff (rst)
    flag_en |=> z_out == $past(alu_flags[0])); // R8
  AST_SAME_CODE_AGREE: assert property (@(posedge clk) disable iff (rst)
    (ra_sel == rb_sel) |-> ra_data == rb_data); // R9
  AST_FLAG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == CODE_FLAG && !flag_en) |=> $stable(flag_q)); // R4
endmodule

// File: tb/sim_regbank16.sv
`timescale 1ns/1ps
module sim_regbank16;
  logic        clk = 1'b0;
  logic        rst, wr_en, flag_en;
  logic [2:0]  wr_sel, ra_sel, rb_sel;
  logic [15:0] wr_data, ra_data, rb_data;
  logic [3:0]  alu_flags;
  logic        z_out;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [15:0] m_gpr [1:4];
  logic [3:0]  m_fl;

  always #2.5 clk = ~clk;

  regbank16 u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_en(flag_en), .alu_flags(alu_flags), .ra_sel(ra_sel), .rb_sel(rb_sel),
    .ra_data(ra_data), .rb_data(rb_data), .z_out(z_out)
  );

  function automatic logic [15:0] exp_read(input logic [2:0] code);
    case (code)
      3'd1, 3'd2, 3'd3, 3'd4: return m_gpr[code];
      3'd5:                   return {12'h000, m_fl};
      default:                return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] code);
    case (code)
      3'd0:    return "R1";
      3'd5:    return "R3";
      3'd6, 3'd7: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare reads, then apply edge to the model
  task automatic cyc(input logic r, input logic we, input logic [2:0] ws,
                     input logic [15:0] wd, input logic fe, input logic [3:0] fl,
                     input logic [2:0] a, input logic [2:0] b, input string tag_a);
    rst = r; wr_en = we; wr_sel = ws; wr_data = wd;
    flag_en = fe; alu_flags = fl; ra_sel = a; rb_sel = b;
    #1;
    chk((tag_a != "") ? tag_a : tag_of(a), ra_data, exp_read(a));
    chk((a == b) ? "R9" : tag_of(b), rb_data, exp_read(b));
    chk("R8", {15'd0, z_out}, {15'd0, m_fl[0]});
    @(posedge clk);
    if (r) begin
      for (int i = 1; i <= 4; i++) m_gpr[i] = 16'h0000;
      m_fl = 4'h0;
    end else begin
      if (we && ws >= 3'd1 && ws <= 3'd4) m_gpr[ws] = wd;
      if (fe) m_fl = fl;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 4; i++) m_gpr[i] = 16'h0000;
    m_fl = 4'h0;
    rst = 1'b1; wr_en = 1'b0; flag_en = 1'b0; wr_sel = '0; wr_data = '0;
    alu_flags = '0; ra_sel = '0; rb_sel = '0;
    @(negedge clk);
    // R7: reset clears everything
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(1, 1, 3'd2, 16'hAAAA, 1, 4'hF, 0, 0, "R7");
    for (int c = 0; c < 8; c++) cyc(0, 0, 0, 0, 0, 0, 3'(c), 3'(7 - c), "R7");
    // R2: load each general register
    cyc(0, 1, 3'd1, 16'h1111, 0, 0, 0, 0, "");
    cyc(0, 1, 3'd2, 16'h2222, 0, 0, 3'd1, 3'd1, "R2");
    cyc(0, 1, 3'd3, 16'h3333, 0, 0, 3'd2, 3'd1, "R2");
    cyc(0, 1, 3'd4, 16'h4444, 0, 0, 3'd3, 3'd2, "R2");
    cyc(0, 0, 3'd4, 16'hDEAD, 0, 0, 3'd4, 3'd3, "R2");
    cyc(0, 0, 0, 0, 0, 0, 3'd4, 3'd4, "R2");
    // R1: write to code 0 then read it back
    cyc(0, 1, 3'd0, 16'hBEEF, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 3'd0, 3'd0, "R1");
    // R5: flag load and hold; R3 layout
    cyc(0, 0, 0, 0, 1, 4'b1010, 3'd5, 3'd5, "R5");
    cyc(0, 0, 0, 0, 0, 4'b0101, 3'd5, 3'd0, "R3");
    cyc(0, 0, 0, 0, 1, 4'b0001, 3'd5, 3'd5, "R5");
    cyc(0, 0, 0, 0, 0, 4'b1110, 3'd5, 3'd1, "R8");
    cyc(0, 0, 0, 0, 0, 0, 3'd5, 3'd5, "R5");
    // R4: write port to code 5 has no effect
    cyc(0, 1, 3'd5, 16'hFFFF, 0, 0, 3'd5, 3'd1, "R4");
    cyc(0, 0, 0, 0, 0, 0, 3'd5, 3'd2, "R4");
    // R6: writes to codes 6 and 7 dropped, reads zero
    cyc(0, 1, 3'd6, 16'h6666, 0, 0, 3'd6, 3'd7, "R6");
    cyc(0, 1, 3'd7, 16'h7777, 0, 0, 3'd7, 3'd6, "R6");
    for (int c = 1; c <= 4; c++) cyc(0, 0, 0, 0, 0, 0, 3'(c), 3'd6, "R6");
    // R10: write and flag load in the same cycle
    cyc(0, 1, 3'd3, 16'h0C0C, 1, 4'b1100, 3'd3, 3'd5, "R10");
    cyc(0, 0, 0, 0, 0, 0, 3'd3, 3'd5, "R10");
    // R7: reset in mid-run
    cyc(1, 1, 3'd1, 16'h5555, 1, 4'hF, 3'd1, 3'd5, "R7");
    for (int c = 0; c < 8; c++) cyc(0, 0, 0, 0, 0, 0, 3'(c), 3'(c), "R7");
    // random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc((r[31:26] == 6'h3F), r[0], r[3:1], r[19:4], r[20], r[24:21],
          3'($urandom), 3'($urandom), "");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule